// File: doc/BRIEF.md
# Pipelined AES-128 Key Schedule

This block expands a 128-bit cipher key into the ten round keys that AES-128 encryption uses after its initial key addition. It is built from ten identical expansion steps in a chain. Each step turns one round key into the next. Every step registers its work in three places: on capture, after the word substitution, and after the word XOR chain. As a result, each step adds exactly three cycles of latency and accepts a new key on every clock.

A cipher key is presented with a valid strobe. Thirty cycles later, the complete set of round keys for that cipher key appears together on a wide bus, qualified by one output valid. Shorter paths are padded with delay lines so that all ten keys line up. Keys may be fed back to back or with arbitrary gaps. A synchronous reset discards everything still in flight.

Top module: `aes_keygen_pipe`

## Requirements
- R1: While reset is sampled high, and on the first cycle after it, `keys_valid` is 0. Reset is synchronous and active high.
- R2: `keys_valid` rises exactly 30 clock edges after the edge that samples `key_valid_in` high. It gives exactly one output cycle for each accepted key, and no output appears without an input.
- R3: For the cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605 and round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R4: A key is four 32-bit words, with word 0 in bits 127:96 and the most significant byte first in each word. Let T be the previous word 3 rotated left by one byte, byte-substituted through the AES S-box, and XORed with the round constant in its top byte. The next key's word 0 is the previous word 0 XOR T. Each following word is the previous key's same word XOR the next key's word before it.
- R5: The round constant for round r (1 to 10) is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 in hexadecimal.
- R6: Round key r sits at `round_keys[128*r-1 : 128*(r-1)]`. All ten keys belong to the same cipher key in the cycle `keys_valid` is high, and `last_key` equals round key 10 in that cycle.
- R7: Keys presented on consecutive cycles each produce their own complete, correct result on consecutive output cycles.
- R8: Cycles with `key_valid_in` low produce no output cycle. Gaps of any length between keys are kept as gaps at the output.
- R9: A reset asserted while keys are in flight discards them. None of them ever raises `keys_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_valid_in | input | 1 | Qualifies `cipher_key` in this cycle |
| cipher_key | input | 128 | Cipher key to expand |
| keys_valid | output | 1 | Qualifies `last_key` and `round_keys` |
| last_key | output | 128 | Round key 10 |
| round_keys | output | 1280 | Round keys 1 to 10, key r in bits 128*r-1 down to 128*(r-1) |

## Verification
The published test vector pins down the byte order, the rotation direction and the first and last round constants. Random keys, together with the all-zero and all-one keys, exercise the S-box across its input range and catch a wrong constant in any round. Back-to-back bursts show that adjacent keys never mix in the delay lines. Random gaps and a reset while keys are in flight show that the valid pipeline tracks the data exactly and drops only what it should.

// File: rtl/aes_keygen_pkg.sv
package aes_keygen_pkg;

    localparam int KEY_W  = 128;
    localparam int WORD_W = 32;

    // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // inverse as x^254 = product of x^(2^i), i = 1..7; maps 0 to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] res;
        sq  = x;
        res = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq);
            res = gf_mul(res, sq);
        end
        return res;
    endfunction

    function automatic logic [7:0] sub_byte(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [WORD_W-1:0] sub_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[8*b +: 8] = sub_byte(w[8*b +: 8]);
        end
        return r;
    endfunction

    // round constant for round r >= 1: repeated doubling in GF(2^8)
    function automatic logic [7:0] round_const(input int r);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 1; i < r; i++) begin
            c = gf_mul(c, 8'h02);
        end
        return c;
    endfunction

endpackage

// File: rtl/aes_keygen_step.sv
module aes_keygen_step
    import aes_keygen_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [KEY_W-1:0] in_key,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_key
);
    localparam logic [7:0] RC = round_const(ROUND);

    typedef struct packed {
        logic              cap_v;
        logic [KEY_W-1:0]  cap_k;
        logic              mid_v;
        logic [KEY_W-1:0]  mid_k;
        logic [WORD_W-1:0] mid_t;
        logic              res_v;
        logic [KEY_W-1:0]  res_k;
    } step_state_t;

    step_state_t st_d, st_q;

    logic [WORD_W-1:0] rot_w;
    logic [WORD_W-1:0] nw0, nw1, nw2, nw3;

    always_comb begin
        st_d       = st_q;
        // capture register
        st_d.cap_v = in_valid;
        st_d.cap_k = in_key;
        // substitution register: rotate word 3, substitute, add constant
        rot_w      = {st_q.cap_k[23:0], st_q.cap_k[31:24]};
        st_d.mid_v = st_q.cap_v;
        st_d.mid_k = st_q.cap_k;
        st_d.mid_t = sub_word(rot_w) ^ {RC, 24'h000000};
        // result register: XOR chain across the four words
        nw0        = st_q.mid_k[127:96] ^ st_q.mid_t;
        nw1        = st_q.mid_k[95:64]  ^ nw0;
        nw2        = st_q.mid_k[63:32]  ^ nw1;
        nw3        = st_q.mid_k[31:0]   ^ nw2;
        st_d.res_v = st_q.mid_v;
        st_d.res_k = {nw0, nw1, nw2, nw3};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cap_v <= 1'b0;
            st_q.mid_v <= 1'b0;
            st_q.res_v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.res_v;
    assign out_key   = st_q.res_k;

endmodule

// File: rtl/aes_keygen_align.sv
module aes_keygen_align #(
    parameter int W     = 128,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_line
            logic [W-1:0] line_d [DEPTH];
            logic [W-1:0] line_q [DEPTH];

            always_comb begin
                line_d[0] = din;
                for (int i = 1; i < DEPTH; i++) begin
                    line_d[i] = line_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                line_q <= line_d;
            end

            assign dout = line_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/aes_keygen_pipe.sv
module aes_keygen_pipe
    import aes_keygen_pkg::*;
#(
    parameter int NUM_ROUNDS = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        key_valid_in,
    input  logic [KEY_W-1:0]            cipher_key,
    output logic                        keys_valid,
    output logic [KEY_W-1:0]            last_key,
    output logic [NUM_ROUNDS*KEY_W-1:0] round_keys
);
    localparam int STEP_LAT = 3;

    logic             chain_v [NUM_ROUNDS+1];
    logic [KEY_W-1:0] chain_k [NUM_ROUNDS+1];

    assign chain_v[0] = key_valid_in;
    assign chain_k[0] = cipher_key;

    generate
        for (genvar g = 0; g < NUM_ROUNDS; g++) begin : g_round
            aes_keygen_step #(
                .ROUND (g + 1)
            ) u_step (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (chain_v[g]),
                .in_key    (chain_k[g]),
                .out_valid (chain_v[g+1]),
                .out_key   (chain_k[g+1])
            );

            aes_keygen_align #(
                .W     (KEY_W),
                .DEPTH (STEP_LAT * (NUM_ROUNDS - 1 - g))
            ) u_align (
                .clk  (clk),
                .din  (chain_k[g+1]),
                .dout (round_keys[g*KEY_W +: KEY_W])
            );
        end
    endgenerate

    assign keys_valid = chain_v[NUM_ROUNDS];
    assign last_key   = chain_k[NUM_ROUNDS];

endmodule

// File: rtl/aes_keygen_pipe_checker.sv
module aes_keygen_pipe_checker #(
    parameter int NUM_ROUNDS = 10
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      key_valid_in,
    input logic                      keys_valid,
    input logic [NUM_ROUNDS*128-1:0] round_keys
);
    localparam int LAT = NUM_ROUNDS * 3;

    logic [LAT-1:0] vhist_q;

    always_ff @(posedge clk) begin
        if (rst) vhist_q <= '0;
        else     vhist_q <= {vhist_q[LAT-2:0], key_valid_in};
    end

    // R1: reset empties the output qualifier
    assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !keys_valid);

    // R2 / R9: output qualifier is the input qualifier delayed by LAT, cleared by reset
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        keys_valid == vhist_q[LAT-1]);

    generate
        for (genvar r = 1; r < NUM_ROUNDS; r++) begin : g_link
            // R4 / R6: adjacent round keys on the bus obey the word chain
            assert_word1_chain_R4: assert property (@(posedge clk) disable iff (rst)
                keys_valid |-> (round_keys[(r+1)*128-33 -: 32] ==
                                (round_keys[r*128-33 -: 32] ^ round_keys[(r+1)*128-1 -: 32])));
            assert_word3_chain_R6: assert property (@(posedge clk) disable iff (rst)
                keys_valid |-> (round_keys[r*128 +: 32] ==
                                (round_keys[(r-1)*128 +: 32] ^ round_keys[r*128+32 +: 32])));
        end
    endgenerate

endmodule

bind aes_keygen_pipe aes_keygen_pipe_checker #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .key_valid_in (key_valid_in),
    .keys_valid   (keys_valid),
    .round_keys   (round_keys)
);

// File: tb/aes_keygen_pipe_bench.sv
module aes_keygen_pipe_bench;
    localparam int NR  = 10;
    localparam int LAT = 30;
    localparam int MAXC = 8192;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           key_valid_in = 1'b0;
    logic [127:0]   cipher_key = '0;
    logic           keys_valid;
    logic [127:0]   last_key;
    logic [NR*128-1:0] round_keys;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;
    string phase = "R1";

    logic         vin [MAXC];
    logic [127:0] kin [MAXC];

    localparam logic [127:0] KAT_KEY  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] KAT_K1   = 128'ha0fafe1788542cb123a339392a6c7605;
    localparam logic [127:0] KAT_K10  = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

    aes_keygen_pipe u_aes_keygen_pipe (
        .clk          (clk),
        .rst          (rst),
        .key_valid_in (key_valid_in),
        .cipher_key   (cipher_key),
        .keys_valid   (keys_valid),
        .last_key     (last_key),
        .round_keys   (round_keys)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        p = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ a;
            a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] iv;
        iv = 8'h00;
        for (int y = 1; y < 256; y++) begin
            if (m_mul(x, 8'(y)) == 8'h01) iv = 8'(y);
        end
        return iv ^ {iv[6:0], iv[7]} ^ {iv[5:0], iv[7:6]} ^ {iv[4:0], iv[7:5]}
                  ^ {iv[3:0], iv[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [NR*128-1:0] m_expand(input logic [127:0] k);
        logic [NR*128-1:0] o;
        logic [127:0] p;
        logic [31:0] t, a, b, c, d;
        logic [7:0] rc;
        p  = k;
        rc = 8'h01;
        for (int r = 0; r < NR; r++) begin
            t = {p[23:0], p[31:24]};
            t = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
            t = t ^ {rc, 24'h0};
            a = p[127:96] ^ t;
            b = p[95:64]  ^ a;
            c = p[63:32]  ^ b;
            d = p[31:0]   ^ c;
            p = {a, b, c, d};
            o[r*128 +: 128] = p;
            rc = m_mul(rc, 8'h02);
        end
        return o;
    endfunction

    task automatic check_outputs();
        logic ev;
        logic [NR*128-1:0] ek;
        ev = (cyc >= LAT) ? vin[cyc-LAT] : 1'b0;
        n_checks++;
        if (keys_valid !== ev) begin
            n_fail++;
            $display("FAIL R2 %s cycle %0d keys_valid actual %b expected %b", phase, cyc, keys_valid, ev);
        end
        if (ev && keys_valid === 1'b1) begin
            ek = m_expand(kin[cyc-LAT]);
            for (int r = 0; r < NR; r++) begin
                n_checks++;
                if (round_keys[r*128 +: 128] !== ek[r*128 +: 128]) begin
                    n_fail++;
                    $display("FAIL R4 R5 %s key %0d actual %h expected %h", phase, r+1,
                             round_keys[r*128 +: 128], ek[r*128 +: 128]);
                end
            end
            n_checks++;
            if (last_key !== ek[(NR-1)*128 +: 128]) begin
                n_fail++;
                $display("FAIL R6 last_key actual %h expected %h", last_key, ek[(NR-1)*128 +: 128]);
            end
            if (kin[cyc-LAT] == KAT_KEY) begin
                n_checks++;
                if (round_keys[127:0] !== KAT_K1 || last_key !== KAT_K10) begin
                    n_fail++;
                    $display("FAIL R3 known answer actual %h/%h expected %h/%h",
                             round_keys[127:0], last_key, KAT_K1, KAT_K10);
                end
            end
        end
    endtask

    // one cycle: check at negedge, then drive next inputs
    task automatic tick(input logic v, input logic [127:0] k, input logic r);
        @(negedge clk);
        check_outputs();
        if (r && !rst) begin
            for (int i = cyc - LAT + 1; i < cyc; i++) if (i >= 0) vin[i] = 1'b0;
        end
        rst          = r;
        key_valid_in = v;
        cipher_key   = k;
        vin[cyc]     = v && !r;
        kin[cyc]     = k;
    endtask

    function automatic logic [127:0] rnd_key();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'h5eed_a35));
        for (int i = 0; i < MAXC; i++) begin vin[i] = 1'b0; kin[i] = '0; end
        // R1: reset, with a valid key offered during reset (must be ignored)
        phase = "R1";
        for (int i = 0; i < 4; i++) tick(1'b1, rnd_key(), 1'b1);
        tick(1'b0, '0, 1'b0);
        n_checks++;
        if (keys_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 keys_valid after reset actual %b expected 0", keys_valid);
        end
        // R3: directed keys
        phase = "R3";
        tick(1'b1, KAT_KEY, 1'b0);
        tick(1'b0, '0, 1'b0);
        tick(1'b1, '0, 1'b0);
        tick(1'b1, '1, 1'b0);
        for (int i = 0; i < 40; i++) tick(1'b0, rnd_key(), 1'b0);
        // R7: back-to-back burst
        phase = "R7";
        for (int i = 0; i < 60; i++) tick(1'b1, rnd_key(), 1'b0);
        // R8: random gaps
        phase = "R8";
        for (int i = 0; i < 300; i++) tick(($urandom % 3) == 0, rnd_key(), 1'b0);
        for (int i = 0; i < 40; i++) tick(1'b0, rnd_key(), 1'b0);
        // R9: reset while keys are in flight
        phase = "R9";
        for (int i = 0; i < 20; i++) tick(1'b1, rnd_key(), 1'b0);
        for (int i = 0; i < 3; i++) tick(1'b1, rnd_key(), 1'b1);
        for (int i = 0; i < 5; i++) tick(1'b1, rnd_key(), 1'b0);
        for (int i = 0; i < 45; i++) tick(1'b0, rnd_key(), 1'b0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule